// File: doc/BRIEF.md
# Dual-Count Pulse-Width Modulator with Polarity-Aware Idle

This block produces one pulse-width modulated output. A programmable divider turns the input clock into a slower tick. Two programmed tick counts shape each period: one count sets the time spent at the active level, and the other sets the time spent at the rest level. No inverter sits on the output. Inverted polarity is obtained by exchanging the two counts and flipping the level the output rests at when it is disabled.

Configuration arrives on parallel inputs and is taken by a commit strobe. A commit that keeps the modulator running is parked in a shadow set. That set is copied into the active set at the end of the running period, so the next period follows the last tick with no gap and no stopped counter. A commit that disables the block, or that arrives while it is disabled, takes effect on the next clock. The output then settles at once at the inactive level that matches the committed polarity.

A pending flag shows that a parked update is waiting. A one-cycle period-end pulse marks each period boundary.

Top module: `dual_phase_pwm`

## Requirements
- R1: With divider value N, the counters advance one tick every N+1 clock cycles, and all phase lengths are counted in ticks.
- R2: With normal polarity (invert input 0) and enable set, each period drives the output high for the high count in ticks and then low for the low count in ticks, and this repeats. A period always begins with its high part.
- R3: With inverted polarity (invert input 1), the two counts swap roles. The output is high for the low count in ticks and then low for the high count in ticks. The period length does not change.
- R4: While disabled, the output rests at the inactive level: 0 for normal polarity and 1 for inverted polarity. A commit that clears enable also applies the polarity committed with it, from the next clock cycle.
- R5: A commit made while disabled, or one that clears enable, takes effect at the next clock edge. A commit that sets enable from the disabled state starts a fresh period at its first tick, with the prescaler and the position both at zero.
- R6: A commit that keeps enable set while running raises the pending output from the next cycle until the period boundary. The running period ends with the old settings, and the new settings apply from the cycle right after the boundary edge. A commit that lands on the boundary cycle itself applies at that boundary, and pending is never raised.
- R7: A count of zero removes its phase from the period. If both counts are zero while enabled, the output stays at the inactive level and every tick counts as a period boundary.
- R8: The period-end output is high for exactly the one clock cycle whose rising edge completes the last tick of a period, and it is low while disabled.
- R9: After reset the block is disabled with normal polarity: the output, pending and period-end are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgDivider | input | DIV_W | Prescaler value N (tick every N+1 clocks) |
| cfgHighCount | input | CNT_W | High-phase length in ticks |
| cfgLowCount | input | CNT_W | Low-phase length in ticks |
| cfgInvert | input | 1 | Polarity: 1 = inverted |
| cfgEnable | input | 1 | Run request |
| cfgCommit | input | 1 | One-cycle strobe that takes the configuration inputs |
| pwmOut | output | 1 | Modulated output |
| updatePending | output | 1 | A parked commit waits for the period boundary |
| periodEnd | output | 1 | High in the cycle that ends a period |

## Verification
The bench builds the block with its default widths: an 8-bit divider and 16-bit counts. It programs small values (dividers 0 to 2 and counts 0 to 5), so every period lasts only a few dozen cycles. With periods that short, the bench can compare every output cycle against a tick-position model across whole periods. It can also place a commit at chosen cycles relative to the boundary, including the boundary cycle itself. Zero counts, the swapped inverted waveform and disabling with a polarity change are each driven on their own.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
  // Strobes sent from the control half to the counting half
  typedef struct packed {
    logic run;      // active enable
    logic restart;  // clear prescaler and position this cycle
  } dppStrobe_t;
endpackage

// File: rtl/dpp_ctrl.sv
module dpp_ctrl
  import dpp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic [CNT_W-1:0] cfgHighCount,
  input  logic [CNT_W-1:0] cfgLowCount,
  input  logic             cfgInvert,
  input  logic             cfgEnable,
  input  logic             cfgCommit,
  input  logic             periodEnd,
  output dppStrobe_t       strobe,
  output logic [DIV_W-1:0] actDivider,
  output logic [CNT_W-1:0] markLen,
  output logic [CNT_W-1:0] spaceLen,
  output logic             idleLevel,
  output logic             updatePending
);

  logic [DIV_W-1:0] shDiv;
  logic [CNT_W-1:0] shHigh, shLow;
  logic             shInv;

  logic [CNT_W-1:0] actHigh, actLow;
  logic             actInv, actEn;

  logic applyDirect, deferCommit, applyShadow;

  // Disables, commits while stopped and commits on the boundary apply at once
  assign applyDirect = cfgCommit && (!actEn || !cfgEnable || periodEnd);
  assign deferCommit = cfgCommit && !applyDirect;
  assign applyShadow = updatePending && periodEnd && !cfgCommit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actDivider    <= '0;
      actHigh       <= '0;
      actLow        <= '0;
      actInv        <= 1'b0;
      actEn         <= 1'b0;
      updatePending <= 1'b0;
    end else if (applyDirect) begin
      actDivider    <= cfgDivider;
      actHigh       <= cfgHighCount;
      actLow        <= cfgLowCount;
      actInv        <= cfgInvert;
      actEn         <= cfgEnable;
      updatePending <= 1'b0;
    end else if (applyShadow) begin
      actDivider    <= shDiv;
      actHigh       <= shHigh;
      actLow        <= shLow;
      actInv        <= shInv;
      updatePending <= 1'b0;
    end else if (deferCommit) begin
      updatePending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shDiv  <= '0;
      shHigh <= '0;
      shLow  <= '0;
      shInv  <= 1'b0;
    end else if (deferCommit) begin
      shDiv  <= cfgDivider;
      shHigh <= cfgHighCount;
      shLow  <= cfgLowCount;
      shInv  <= cfgInvert;
    end
  end

  // Polarity only swaps which count feeds each phase, and the idle level
  always_comb begin
    markLen        = actInv ? actLow  : actHigh;
    spaceLen       = actInv ? actHigh : actLow;
    idleLevel      = actInv;
    strobe.run     = actEn;
    strobe.restart = applyDirect && !actEn;
  end

  // R6
  pendHold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updatePending && !periodEnd && !cfgCommit |=> updatePending);
  // R6
  pendClear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updatePending && periodEnd |=> !updatePending);
  // R6
  pendRun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updatePending |-> actEn);
  // R4
  disableIdle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfgCommit && !cfgEnable |=> (!actEn && idleLevel == $past(cfgInvert)));

endmodule

// File: rtl/dpp_datapath.sv
module dpp_datapath
  import dpp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dppStrobe_t       strobe,
  input  logic [DIV_W-1:0] divider,
  input  logic [CNT_W-1:0] markLen,
  input  logic [CNT_W-1:0] spaceLen,
  input  logic             idleLevel,
  output logic             pwmOut,
  output logic             periodEnd
);

  localparam int POS_W = CNT_W + 1;

  logic [DIV_W-1:0] presc;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] total;
  logic             tick, lastTick, emptyPeriod;

  assign total       = POS_W'(markLen) + POS_W'(spaceLen);
  assign emptyPeriod = (total == '0);
  assign tick        = strobe.run && (presc == divider);
  assign lastTick    = emptyPeriod || (pos == total - 1'b1);
  assign periodEnd   = tick && lastTick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      pos   <= '0;
    end else if (!strobe.run || strobe.restart) begin
      presc <= '0;
      pos   <= '0;
    end else if (tick) begin
      presc <= '0;
      pos   <= lastTick ? '0 : pos + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  always_comb begin
    if (!strobe.run || emptyPeriod) pwmOut = idleLevel;
    else                            pwmOut = (pos < POS_W'(markLen));
  end

  // R1
  prescBound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.run |-> presc <= divider);
  // R2
  posBound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.run && !emptyPeriod |-> pos < total);
  // R8
  periodWrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |=> (pos == '0 && presc == '0));
  // R5
  freshStart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe.run) |-> (pos == '0 && presc == '0));
  // R8
  endRun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |-> strobe.run);

endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dpp_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfgDivider,
  input  logic [CNT_W-1:0] cfgHighCount,
  input  logic [CNT_W-1:0] cfgLowCount,
  input  logic             cfgInvert,
  input  logic             cfgEnable,
  input  logic             cfgCommit,
  output logic             pwmOut,
  output logic             updatePending,
  output logic             periodEnd
);

  dppStrobe_t       strobe;
  logic [DIV_W-1:0] actDivider;
  logic [CNT_W-1:0] markLen, spaceLen;
  logic             idleLevel;

  dpp_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfgDivider    (cfgDivider),
    .cfgHighCount  (cfgHighCount),
    .cfgLowCount   (cfgLowCount),
    .cfgInvert     (cfgInvert),
    .cfgEnable     (cfgEnable),
    .cfgCommit     (cfgCommit),
    .periodEnd     (periodEnd),
    .strobe        (strobe),
    .actDivider    (actDivider),
    .markLen       (markLen),
    .spaceLen      (spaceLen),
    .idleLevel     (idleLevel),
    .updatePending (updatePending)
  );

  dpp_datapath #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .divider   (actDivider),
    .markLen   (markLen),
    .spaceLen  (spaceLen),
    .idleLevel (idleLevel),
    .pwmOut    (pwmOut),
    .periodEnd (periodEnd)
  );

endmodule

// File: tb/tb_dual_phase_pwm.sv
`timescale 1ns/1ps
module tb_dual_phase_pwm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfgDivider = '0;
  logic [15:0] cfgHighCount = '0, cfgLowCount = '0;
  logic        cfgInvert = 1'b0, cfgEnable = 1'b0, cfgCommit = 1'b0;
  logic        pwmOut, updatePending, periodEnd;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  dual_phase_pwm dut (
    .clk(clk), .rst_n(rst_n), .cfgDivider(cfgDivider),
    .cfgHighCount(cfgHighCount), .cfgLowCount(cfgLowCount),
    .cfgInvert(cfgInvert), .cfgEnable(cfgEnable), .cfgCommit(cfgCommit),
    .pwmOut(pwmOut), .updatePending(updatePending), .periodEnd(periodEnd)
  );

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Model: output level k cycles after the applying edge
  function automatic int expOut(int k, int dv, int hi, int lo, int inv);
    int total = hi + lo;
    int mark  = inv ? lo : hi;
    if (total == 0) return inv;
    return (((k / (dv + 1)) % total) < mark) ? 1 : 0;
  endfunction

  function automatic int expEnd(int k, int dv, int hi, int lo);
    int total = hi + lo;
    if ((k % (dv + 1)) != dv) return 0;
    if (total == 0) return 1;
    return (((k / (dv + 1)) % total) == total - 1) ? 1 : 0;
  endfunction

  // Called at a negedge; returns at the negedge after the capturing edge
  task automatic doCommit(int dv, int hi, int lo, int inv, int en);
    cfgDivider = 8'(dv); cfgHighCount = 16'(hi); cfgLowCount = 16'(lo);
    cfgInvert = 1'(inv); cfgEnable = 1'(en); cfgCommit = 1'b1;
    @(negedge clk);
    cfgCommit = 1'b0;
  endtask

  task automatic runModel(string tag, int n, int dv, int hi, int lo, int inv);
    for (int k = 0; k < n; k++) begin
      check({tag, " out"}, pwmOut, expOut(k, dv, hi, lo, inv));
      check({tag, " periodEnd"}, periodEnd, expEnd(k, dv, hi, lo));
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    check("R9 out", pwmOut, 0);
    check("R9 pending", updatePending, 0);
    check("R9 periodEnd", periodEnd, 0);
  endtask

  task automatic testNormal();
    doCommit(0, 0, 0, 0, 0);
    doCommit(1, 3, 2, 0, 1);
    runModel("R1 R2 R8 div1", 30, 1, 3, 2, 0);
    doCommit(0, 0, 0, 0, 0);
    doCommit(0, 1, 4, 0, 1);
    runModel("R2 div0", 15, 0, 1, 4, 0);
    doCommit(0, 0, 0, 0, 0);
    doCommit(2, 2, 1, 0, 1);
    runModel("R1 div2", 27, 2, 2, 1, 0);
  endtask

  task automatic testInverted();
    doCommit(0, 0, 0, 1, 0);
    doCommit(2, 2, 3, 1, 1);
    runModel("R3 inverted", 45, 2, 2, 3, 1);
  endtask

  task automatic testDisablePolarity();
    doCommit(0, 0, 0, 0, 0);
    doCommit(0, 3, 3, 0, 1);
    runModel("R2 pre", 2, 0, 3, 3, 0);
    doCommit(0, 3, 3, 1, 0);
    for (int i = 0; i < 5; i++) begin
      check("R4 idle inverted", pwmOut, 1);
      check("R8 no end while off", periodEnd, 0);
      @(negedge clk);
    end
    doCommit(0, 3, 3, 0, 0);
    for (int i = 0; i < 5; i++) begin
      check("R4 idle normal", pwmOut, 0);
      @(negedge clk);
    end
  endtask

  task automatic testFreshStart();
    doCommit(0, 0, 0, 0, 0);
    doCommit(1, 2, 3, 0, 1);
    runModel("R5 first", 5, 1, 2, 3, 0);
    doCommit(1, 2, 3, 0, 0);
    doCommit(1, 2, 3, 0, 1);
    runModel("R5 restart", 20, 1, 2, 3, 0);
  endtask

  task automatic testZero();
    doCommit(0, 0, 0, 0, 0);
    doCommit(0, 0, 3, 0, 1);
    for (int i = 0; i < 8; i++) begin
      check("R7 high skipped", pwmOut, 0);
      @(negedge clk);
    end
    doCommit(0, 0, 0, 0, 0);
    doCommit(0, 3, 0, 0, 1);
    for (int i = 0; i < 8; i++) begin
      check("R7 low skipped", pwmOut, 1);
      @(negedge clk);
    end
    doCommit(0, 0, 0, 1, 0);
    doCommit(1, 0, 0, 1, 1);
    runModel("R7 both zero", 10, 1, 0, 0, 1);
  endtask

  // Run A, commit B at sample cK, expect B from the boundary on
  task automatic testBoundary(string tag, int cK);
    int period = 2 * 4;
    doCommit(0, 0, 0, 0, 0);
    doCommit(1, 2, 2, 0, 1);
    for (int k = 0; k < period + 15; k++) begin
      if (k < period) begin
        check({tag, " old out"}, pwmOut, expOut(k, 1, 2, 2, 0));
        check({tag, " old end"}, periodEnd, expEnd(k, 1, 2, 2));
      end else begin
        check({tag, " new out"}, pwmOut, expOut(k - period, 0, 1, 2, 0));
        check({tag, " new end"}, periodEnd, expEnd(k - period, 0, 1, 2));
      end
      check({tag, " pending"}, updatePending,
            (k > cK && k < period) ? 1 : 0);
      if (k == cK) begin
        cfgDivider = 8'd0; cfgHighCount = 16'd1; cfgLowCount = 16'd2;
        cfgInvert = 1'b0; cfgEnable = 1'b1; cfgCommit = 1'b1;
      end else begin
        cfgCommit = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #1_500_000;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testInverted();
    testDisablePolarity();
    testFreshStart();
    testZero();
    testBoundary("R6 mid-period", 3);
    testBoundary("R6 on boundary", 7);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule